// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Controller

This block connects a CPU-style 8-bit bus to three 8-bit parallel ports, called A, B and C. Software chooses the direction of port A, port B, and each 4-bit half of port C by writing a configuration word. The ports then act as simple latched inputs or latched outputs. Port C can also be changed one bit at a time, with no read-modify-write. The CPU side uses active-low chip select, read and write strobes and a 2-bit register select. The three-state system bus is split into a data-in bus, a data-out bus and an output-enable.

Writes to address 3 come in two formats, and bit 7 tells them apart. When bit 7 is 1, the word sets the port directions and clears every output latch. When bit 7 is 0, the word sets or clears one port C bit and leaves the directions alone. All strobes are sampled on the system clock. A write takes effect at the first clock edge that sees the write strobe high again after it was low with chip select asserted.

Top module: `pario_top`

## Requirements
- R1: Register select `addr` picks the target: 0 = port A, 1 = port B, 2 = port C, 3 = configuration.
- R2: While `rst` is high, the configuration becomes 9Bh and all output latches become 0. After reset, every port and half-port is an input, so all `*_oe` are 0.
- R3: A write to address 3 with bit 7 = 0 sets port C bit `din[3:1]` to `din[0]`. All other latches and all directions are unchanged.
- R4: `dout_en` is high only while both `cs_n` and `rd_n` are low.
- R5: A read at address 3 never drives the bus: `dout_en` stays 0.
- R6: In a configuration word, bit 3 sets the direction of PC7..PC4 and bit 0 sets the direction of PC3..PC0 (1 = input). Each half changes only its own `pc_oe` bits and its own read-back.
- R7: In a configuration word, bit 4 sets the direction of port A and bit 1 sets port B (1 = input). Bits 6:5 and 2 are accepted but have no effect. An output port drives `*_oe` high, and its pin outputs equal its latch.
- R8: A read of an input port or input half returns the pin values sampled at the previous clock edge.
- R9: A configuration write (bit 7 = 1) clears the A, B and C output latches to 0.
- R10: A write commits at the first clock edge where `wr_n` is high after it was sampled low with `cs_n` low. It uses the address and data sampled in the last cycle of the strobe. A strobe with `cs_n` high changes nothing.
- R11: A read of an output port or output half returns its latch value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Data from the CPU bus |
| dout | output | 8 | Data to the CPU bus, 0 when not enabled |
| dout_en | output | 1 | Output enable for the CPU bus |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin outputs (latch) |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin outputs (latch) |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C pin outputs (latch) |
| pc_oe | output | 8 | Port C per-pin output enable |

## Verification
A wrong direction bit shows up at once, because the `*_oe` outputs follow the configuration. It also changes the read-back source at the next read. A corrupted output latch shows on the pin outputs in the cycle after the faulty write commits. A stale or misdecoded set/reset shows on a single `pc_out` bit. A missing clear after a configuration word leaves old latch values on the pins right away. Each bus operation is therefore followed by a comparison of all port outputs and a read-back of every port.

// File: rtl/pario_pkg.sv
package pario_pkg;
  localparam int DW   = 8;
  localparam int HW   = DW / 2;
  localparam int IDXW = $clog2(DW);

  localparam logic [DW-1:0] CFG_RESET = 8'h9B;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CFG = 2'd3
  } sel_e;

  // direction bits kept from a configuration word (1 = input)
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;

  function automatic logic is_cfg_word(input logic [DW-1:0] w);
    return w[7];
  endfunction

  function automatic dir_t cfg_dirs(input logic [DW-1:0] w);
    dir_t d;
    d.a_in  = w[4];
    d.cu_in = w[3];
    d.b_in  = w[1];
    d.cl_in = w[0];
    return d;
  endfunction

  function automatic logic [IDXW-1:0] bit_sel(input logic [DW-1:0] w);
    return w[IDXW:1];
  endfunction

  function automatic logic bit_val(input logic [DW-1:0] w);
    return w[0];
  endfunction
endpackage

// File: rtl/pario_busif.sv
module pario_busif
  import pario_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output logic          wr_evt,
  output logic [1:0]    wr_addr,
  output logic [DW-1:0] wr_data
);
  logic wr_n_q, cs_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_q  <= 1'b1;
      cs_n_q  <= 1'b1;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_n_q <= wr_n;
      cs_n_q <= cs_n;
      if (!wr_n) begin
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end

  // strobe seen low with select last cycle, high now
  assign wr_evt = !wr_n_q && !cs_n_q && wr_n;
endmodule

// File: rtl/pario_cfg.sv
module pario_cfg
  import pario_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_evt,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output dir_t          dirs,
  output logic          mode_evt,
  output logic          sr_evt
);
  logic cfg_hit;

  assign cfg_hit  = wr_evt && (wr_addr == SEL_CFG);
  assign mode_evt = cfg_hit && is_cfg_word(wr_data);
  assign sr_evt   = cfg_hit && !is_cfg_word(wr_data);

  always_ff @(posedge clk) begin
    if (rst)           dirs <= cfg_dirs(CFG_RESET);
    else if (mode_evt) dirs <= cfg_dirs(wr_data);
  end
endmodule

// File: rtl/pario_port.sv
module pario_port
  import pario_pkg::*;
#(
  parameter int W = DW,
  localparam int NH = 2,
  localparam int SW = W / NH,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NH-1:0] half_in,   // [1] upper half, [0] lower half, 1 = input
  input  logic [W-1:0]  pin_in,
  input  logic          wr_all,
  input  logic [W-1:0]  wr_val,
  input  logic          wr_bit,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_v,
  input  logic          clr,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] out_q;
  logic [W-1:0] smp_q;

  always_ff @(posedge clk) begin
    if (rst) smp_q <= '0;
    else     smp_q <= pin_in;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  out_q <= '0;
    else if (wr_all) out_q <= wr_val;
    else if (wr_bit) out_q[bit_idx] <= bit_v;
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign pin_oe[h*SW +: SW]  = {SW{!half_in[h]}};
    assign rd_data[h*SW +: SW] = half_in[h] ? smp_q[h*SW +: SW] : out_q[h*SW +: SW];
  end

  assign pin_out = out_q;
endmodule

// File: rtl/pario_top.sv
module pario_top
  import pario_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  logic          wr_evt, mode_evt, sr_evt;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  dir_t          dirs;
  logic [DW-1:0] rd_a, rd_b, rd_c;

  pario_busif u_bus (
    .clk, .rst, .cs_n, .wr_n, .addr, .din,
    .wr_evt, .wr_addr, .wr_data
  );

  pario_cfg u_cfg (
    .clk, .rst, .wr_evt, .wr_addr, .wr_data,
    .dirs, .mode_evt, .sr_evt
  );

  pario_port #(.W(DW)) u_pa (
    .clk, .rst,
    .half_in ({dirs.a_in, dirs.a_in}),
    .pin_in  (pa_in),
    .wr_all  (wr_evt && wr_addr == SEL_A),
    .wr_val  (wr_data),
    .wr_bit  (1'b0),
    .bit_idx ('0),
    .bit_v   (1'b0),
    .clr     (mode_evt),
    .pin_out (pa_out),
    .pin_oe  (pa_oe),
    .rd_data (rd_a)
  );

  pario_port #(.W(DW)) u_pb (
    .clk, .rst,
    .half_in ({dirs.b_in, dirs.b_in}),
    .pin_in  (pb_in),
    .wr_all  (wr_evt && wr_addr == SEL_B),
    .wr_val  (wr_data),
    .wr_bit  (1'b0),
    .bit_idx ('0),
    .bit_v   (1'b0),
    .clr     (mode_evt),
    .pin_out (pb_out),
    .pin_oe  (pb_oe),
    .rd_data (rd_b)
  );

  pario_port #(.W(DW)) u_pc (
    .clk, .rst,
    .half_in ({dirs.cu_in, dirs.cl_in}),
    .pin_in  (pc_in),
    .wr_all  (wr_evt && wr_addr == SEL_C),
    .wr_val  (wr_data),
    .wr_bit  (sr_evt),
    .bit_idx (bit_sel(wr_data)),
    .bit_v   (bit_val(wr_data)),
    .clr     (mode_evt),
    .pin_out (pc_out),
    .pin_oe  (pc_oe),
    .rd_data (rd_c)
  );

  // read path: configuration is write-only, never driven
  always_comb begin
    dout_en = 1'b0;
    dout    = '0;
    if (!cs_n && !rd_n) begin
      unique case (sel_e'(addr))
        SEL_A:   begin dout_en = 1'b1; dout = rd_a; end
        SEL_B:   begin dout_en = 1'b1; dout = rd_b; end
        SEL_C:   begin dout_en = 1'b1; dout = rd_c; end
        SEL_CFG: begin dout_en = 1'b0; dout = '0;   end
      endcase
    end
  end
endmodule

// File: rtl/pario_chk.sv
module pario_chk
  import pario_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          rd_n,
  input logic [1:0]    addr,
  input logic          dout_en,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pb_oe,
  input logic [DW-1:0] pc_oe,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pb_out,
  input logic [DW-1:0] pc_out,
  input logic          wr_evt,
  input logic          mode_evt,
  input logic          sr_evt
);
  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= rst;

  // R2: the cycle after reset, everything is input and latches are clear
  always_ff @(posedge clk) begin
    if (rst_seen && !rst) begin
      a_r2_reset_state: assert (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                                pa_out == '0 && pb_out == '0 && pc_out == '0);
    end
  end

  a_r4_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> !dout_en);

  a_r5_cfg_unreadable: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd3) |-> !dout_en);

  a_r3_sr_keeps_dirs: assert property (@(posedge clk) disable iff (rst)
    sr_evt |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  a_r9_cfg_clears: assert property (@(posedge clk) disable iff (rst)
    mode_evt |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

  a_r10_only_on_commit: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                 $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

bind pario_top pario_chk i_chk (.*);

// File: tb/test_pario_top.sv
module test_pario_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] la, lb, lc;
  logic a_in, b_in, cu_in, cl_in;

  always #2.5 clk = ~clk;

  pario_top i_pario_top (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic void model_reset();
    la = 0; lb = 0; lc = 0;
    a_in = 1; b_in = 1; cu_in = 1; cl_in = 1;
  endfunction

  function automatic void model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: la = d;
      2'd1: lb = d;
      2'd2: lc = d;
      default:
        if (d[7]) begin
          a_in = d[4]; cu_in = d[3]; b_in = d[1]; cl_in = d[0];
          la = 0; lb = 0; lc = 0;
        end else lc[d[3:1]] = d[0];
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return a_in ? pa_in : la;
      2'd1: return b_in ? pb_in : lb;
      default: return {cu_in ? pc_in[7:4] : lc[7:4], cl_in ? pc_in[3:0] : lc[3:0]};
    endcase
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    cs_n = !sel; addr = a; din = d; wr_n = 0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1;
    @(negedge clk);   // commit edge passed
    cs_n = 1; din = $urandom;
    if (sel) model_write(a, d);
  endtask

  task automatic set_pins(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk);
    pa_in = a; pb_in = b; pc_in = c;
    @(negedge clk);   // sampled at the edge in between
  endtask

  task automatic check_pins(input string req);
    check({req, " pa_out"}, pa_out, la);
    check({req, " pb_out"}, pb_out, lb);
    check({req, " pc_out"}, pc_out, lc);
    check({req, " pa_oe"}, pa_oe, {8{!a_in}});
    check({req, " pb_oe"}, pb_oe, {8{!b_in}});
    check({req, " pc_oe"}, pc_oe, {{4{!cu_in}}, {4{!cl_in}}});
  endtask

  task automatic read_check(input logic [1:0] a, input string req);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = a;
    #1;
    if (a == 2'd3) check({req, " R5 cfg read en"}, dout_en, 0);
    else begin
      check({req, " R1 read en"}, dout_en, 1);
      check({req, " R1 read data"}, dout, exp_read(a));
    end
    cs_n = 1; rd_n = 1;
    #1;
    check({req, " R4 idle en"}, dout_en, 0);
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < 4; k++) read_check(k[1:0], req);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R2 reset state
    check_pins("R2");
    set_pins(8'h5A, 8'hC3, 8'h96);
    read_all("R2/R8");

    // R4: read strobe without select
    @(negedge clk); cs_n = 1; rd_n = 0; addr = 0; #1;
    check("R4 rd without cs", dout_en, 0);
    rd_n = 1;

    // R7/R9: all outputs, then write ports
    bus_write(3, 8'h80, 1);
    check_pins("R7");
    bus_write(0, 8'hA5, 1);
    bus_write(1, 8'h3C, 1);
    bus_write(2, 8'hF0, 1);
    check_pins("R11");
    read_all("R11");

    // R3: set/reset individual bits, directions unchanged
    bus_write(3, 8'h01, 1);   // bit0 = 1
    bus_write(3, 8'h0F, 1);   // bit7 = 1
    bus_write(3, 8'h08, 1);   // bit4 = 0
    check("R3 pc_out", pc_out, 8'hE1);
    check_pins("R3");

    // R10: strobe with cs high ignored
    bus_write(0, 8'h11, 0);
    check("R10 no cs", pa_out, 8'hA5);

    // R9: cfg word clears latches
    bus_write(3, 8'h89, 1);   // cu in, cl in, a out, b out
    check("R9 cleared a", pa_out, 8'h00);
    check_pins("R9/R6");

    // R6: split halves
    bus_write(3, 8'h88, 1);   // upper in, lower out
    bus_write(2, 8'h7E, 1);
    set_pins(8'h00, 8'h00, 8'hB4);
    read_check(2, "R6 upper in lower out");
    bus_write(3, 8'h81, 1);   // upper out, lower in
    bus_write(2, 8'h7E, 1);
    set_pins(8'h00, 8'h00, 8'h4B);
    read_check(2, "R6 upper out lower in");
    check_pins("R6");

    // R8: input pins follow after one edge
    bus_write(3, 8'h9B, 1);
    set_pins(8'h12, 8'h34, 8'h56);
    read_all("R8");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom);
      d = 8'($urandom);
      if (a == 3 && ($urandom % 4) != 0) d[7] = 0;
      bus_write(a, d, ($urandom % 8) != 0);
      if (($urandom % 3) == 0) set_pins(8'($urandom), 8'($urandom), 8'($urandom));
      check_pins("R7/R10 random");
      read_check(2'($urandom), "R1 random");
    end

    // R2: reset mid-operation
    bus_write(3, 8'h80, 1);
    bus_write(1, 8'hFF, 1);
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    model_reset();
    @(negedge clk);
    check_pins("R2 re-reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule